// File: doc/BRIEF.md
# SIMD Pairwise Widening Add-Accumulate Unit

This execution unit sits in a 128-bit vector datapath. It takes one 32-bit instruction word together with a source vector and the current contents of the destination vector. It adds each pair of neighbouring source elements after extending both to double width, and writes one wide lane per pair. The instruction picks sign or zero extension, picks whether the old destination lane is added in, and picks a 64-bit or 128-bit operating width. In the 64-bit form the upper half of the result is zero.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. The result is held in one register stage. An input beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its beat is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result and the illegal flag hold steady and no new input is accepted. A word that does not decode, or that uses the reserved size, produces an output beat with `out_illegal` set. That beat carries the unchanged destination value.

Top module: `pairsum_unit`

## Requirements
- R1: A word decodes only when all of these hold: bit 31 = 0, bits 28:24 = 01110, bit 21 = 1, bits 20:16 = 00000, and bits 15:10 = 011010 or 001010. Any other word sets `out_illegal` and returns `in_dst` unchanged as the result.
- R2: Instruction bit 29 = 0 sign-extends the source elements and bit 29 = 1 zero-extends them.
- R3: Size (bits 23:22) = 0, 1 or 2 selects 8-, 16- or 32-bit source elements. Wide lane i is the sum of extended source elements 2i and 2i+1, where element k occupies bits k*E upward.
- R4: When bits 15:10 = 011010, wide lane i of `in_dst` is added to the pair sum. When they are 001010, it is not added.
- R5: Bit 30 (Q) = 0 selects a 64-bit width, giving 4, 2 or 1 lanes, and result bits 127:64 are zero. Q = 1 gives 8, 4 or 2 lanes over the full 128 bits.
- R6: Every sum wraps modulo 2 to the power of the wide lane width.
- R7: Size = 3 sets `out_illegal` and returns `in_dst` unchanged.
- R8: An accepted beat appears on the output one clock later. Synchronous active-high `rst` clears `out_valid`.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` && !`out_ready`, the output holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| in_dst | input | 128 | Current destination vector |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 128 | New destination value |
| out_illegal | output | 1 | Word did not decode or used a reserved size |

## Verification
The checker assumes that `out_ready` and the input stream fields are known values in every clock cycle after reset. It also assumes that the instruction and the destination of an accepted beat describe the beat the unit registers, because it keeps its own copy of the Q bit, the size field and the destination at acceptance. The bench drives every input on the falling edge and holds `in_valid` high only for complete beats. It never leaves any input undriven after reset. Whenever it applies back-pressure, it keeps the next beat stable until that beat is accepted.

// File: rtl/pairsum_pkg.sv
package pairsum_pkg;
  localparam int INSN_W = 32;
  localparam int VEC_W  = 128;
  localparam int BASE_E = 8;
  localparam int NSIZES = 3;
  localparam logic [4:0] OPC_HI    = 5'b01110;
  localparam logic [5:0] FN_ACCUM  = 6'b011010;
  localparam logic [5:0] FN_PLAIN  = 6'b001010;

  typedef struct packed {
    logic       legal;
    logic       q;
    logic       uns;
    logic       acc;
    logic [1:0] size;
  } dec_t;
endpackage

// File: rtl/pairsum_decode.sv
module pairsum_decode
  import pairsum_pkg::*;
(
  input  logic [31:10] word,
  output dec_t         dec
);
  logic form_ok;
  always_comb begin
    form_ok = (word[31] == 1'b0) && (word[28:24] == OPC_HI) &&
              (word[21] == 1'b1) && (word[20:16] == 5'b00000) &&
              ((word[15:10] == FN_ACCUM) || (word[15:10] == FN_PLAIN));
    dec.size  = word[23:22];
    dec.q     = word[30];
    dec.uns   = word[29];
    dec.acc   = (word[15:10] == FN_ACCUM);
    dec.legal = form_ok && (word[23:22] != 2'd3);
  end
endmodule

// File: rtl/pairsum_lanes.sv
module pairsum_lanes #(
  parameter int DATA_W = 128,
  parameter int ELEM_W = 8
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic              uns,
  input  logic              acc,
  output logic [DATA_W-1:0] res
);
  localparam int WIDE_W = 2 * ELEM_W;
  localparam int NLANES = DATA_W / WIDE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [ELEM_W-1:0] lo, hi;
    logic [WIDE_W-1:0] ext_lo, ext_hi, addend;
    always_comb begin
      lo     = src[(2*i)*ELEM_W +: ELEM_W];
      hi     = src[(2*i+1)*ELEM_W +: ELEM_W];
      ext_lo = {{ELEM_W{~uns & lo[ELEM_W-1]}}, lo};
      ext_hi = {{ELEM_W{~uns & hi[ELEM_W-1]}}, hi};
      addend = acc ? dst[i*WIDE_W +: WIDE_W] : '0;
      res[i*WIDE_W +: WIDE_W] = ext_lo + ext_hi + addend;
    end
  end
endmodule

// File: rtl/pairsum_datapath.sv
module pairsum_datapath
  import pairsum_pkg::*;
#(
  parameter int DATA_W = VEC_W,
  parameter int E0     = BASE_E,
  parameter int NS     = NSIZES
) (
  input  dec_t              dec,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] res
);
  localparam int HALF_W = DATA_W / 2;
  logic [DATA_W-1:0] by_size [NS];

  for (genvar s = 0; s < NS; s++) begin : g_size
    pairsum_lanes #(.DATA_W(DATA_W), .ELEM_W(E0 << s)) u_lanes (
      .src(src), .dst(dst), .uns(dec.uns), .acc(dec.acc), .res(by_size[s])
    );
  end

  always_comb begin
    res = dst;
    if (dec.legal) begin
      res = '0;
      for (int s = 0; s < NS; s++)
        if (dec.size == s[1:0]) res = by_size[s];
      if (!dec.q) res[DATA_W-1:HALF_W] = '0;
    end
  end
endmodule

// File: rtl/pairsum_unit.sv
module pairsum_unit
  import pairsum_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_insn,
  input  logic [127:0] in_src,
  input  logic [127:0] in_dst,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_result,
  output logic         out_illegal
);
  dec_t         dec;
  logic [127:0] res_c;
  logic         unused_fields;

  assign unused_fields = ^in_insn[9:0];
  assign in_ready = !out_valid || out_ready;

  pairsum_decode u_dec (.word(in_insn[31:10]), .dec(dec));

  pairsum_datapath #(.DATA_W(VEC_W)) u_dp (
    .dec(dec), .src(in_src), .dst(in_dst), .res(res_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      out_result  <= res_c;
      out_illegal <= !dec.legal;
    end
  end
endmodule

// File: rtl/pairsum_unit_chk.sv
module pairsum_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [31:0]  in_insn,
  input logic [127:0] in_dst,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_result,
  input logic         out_illegal
);
  logic         seen_q;
  logic [1:0]   seen_size;
  logic [127:0] seen_dst;
  logic         past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b1;
    if (in_valid && in_ready) begin
      seen_q    <= in_insn[30];
      seen_size <= in_insn[23:22];
      seen_dst  <= in_dst;
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_reset_clear_r8: assert property (@(posedge clk)
    (past_ok === 1'b1 && $past(rst)) |-> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  p_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && !seen_q) |-> (out_result[127:64] == 64'd0));

  p_reserved_size_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_size == 2'd3) |-> out_illegal);

  p_illegal_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == seen_dst));
endmodule

bind pairsum_unit pairsum_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_insn(in_insn), .in_dst(in_dst), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/pairsum_unit_test.sv
module pairsum_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_src = '0;
  logic [127:0] in_dst = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic         out_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pairsum_unit uut (.*);

  // table: {q, uns, size[1:0], acc, src, dst}
  localparam int NV = 10;
  localparam logic [260:0] VEC [NV] = '{
    {1'b1,1'b0,2'd0,1'b0, 128'h80FF7F01_1234ABCD_00FF8001_FEDCBA98, 128'h0},
    {1'b1,1'b1,2'd0,1'b0, 128'h80FF7F01_1234ABCD_00FF8001_FEDCBA98, 128'h0},
    {1'b1,1'b0,2'd1,1'b1, 128'h8000FFFF_7FFF0001_DEADBEEF_01234567, 128'h00010002_FFFF8000_12345678_9ABCDEF0},
    {1'b1,1'b1,2'd1,1'b1, 128'h8000FFFF_7FFF0001_DEADBEEF_01234567, 128'h00010002_FFFF8000_12345678_9ABCDEF0},
    {1'b1,1'b0,2'd2,1'b0, 128'h80000000_80000000_7FFFFFFF_00000001, 128'h0},
    {1'b1,1'b1,2'd2,1'b1, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'hFFFFFFFF_FFFFFFFF_00000000_00000005},
    {1'b0,1'b0,2'd0,1'b1, 128'hFFEEDDCC_BBAA9988_77665544_33221100, 128'hAAAA5555_AAAA5555_01020304_05060708},
    {1'b0,1'b1,2'd1,1'b0, 128'hFFEEDDCC_BBAA9988_77665544_33221100, 128'hAAAA5555_AAAA5555_01020304_05060708},
    {1'b0,1'b0,2'd2,1'b1, 128'hFFEEDDCC_BBAA9988_87665544_83221100, 128'h11111111_22222222_33333333_44444444},
    {1'b1,1'b1,2'd3,1'b0, 128'h0123456789ABCDEF_0123456789ABCDEF, 128'hCAFEF00D_00C0FFEE_5A5A5A5A_A5A5A5A5}
  };

  function automatic logic [31:0] mk(input logic q, input logic u, input logic [1:0] sz, input logic acc);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'b00000, acc ? 6'b011010 : 6'b001010, 5'd3, 5'd7};
  endfunction

  function automatic logic [127:0] model(input logic q, input logic u, input logic [1:0] sz,
                                         input logic acc, input logic [127:0] s, input logic [127:0] d);
    logic [127:0] r;
    int e, n;
    r = '0;
    if (sz == 2'd3) return d;
    e = 8 << sz;
    n = (q ? 128 : 64) / (2 * e);
    for (int i = 0; i < n; i++) begin
      logic [63:0] a, b, c, m, sum;
      m = (64'd1 << e) - 64'd1;
      a = (s >> (2*i*e)) & m;
      b = (s >> ((2*i+1)*e)) & m;
      if (!u && a[e-1]) a = a | ~m;
      if (!u && b[e-1]) b = b | ~m;
      c = acc ? 64'((d >> (i*2*e))) : 64'd0;
      sum = a + b + c;
      if (e < 32) sum = sum & ((64'd1 << (2*e)) - 64'd1);
      r = r | (128'(sum) << (i*2*e));
    end
    return r;
  endfunction

  task automatic chk1(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [127:0] s, input logic [127:0] d);
    @(negedge clk);
    in_insn = w; in_src = s; in_dst = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk1("R8 reset out_valid", {127'd0, out_valid}, 128'd0);
    chk1("R9 reset in_ready", {127'd0, in_ready}, 128'd1);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      logic q, u, a;
      logic [1:0] sz;
      logic [127:0] s, d;
      {q, u, sz, a, s, d} = VEC[k];
      send(mk(q, u, sz, a), s, d);
      chk1("R8 valid one cycle later", {127'd0, out_valid}, 128'd1);
      chk1("R3 R2 R4 R5 table result", out_result, model(q, u, sz, a, s, d));
      chk1("R7 illegal flag", {127'd0, out_illegal}, {127'd0, sz == 2'd3});
    end

    // directed corner values, hand-derived
    send(mk(1, 1, 0, 0), {16{8'hFF}}, '0);
    chk1("R2 unsigned bytes 0xFF", out_result, {8{16'h01FE}});
    send(mk(1, 0, 0, 0), {16{8'hFF}}, '0);
    chk1("R2 signed bytes 0xFF", out_result, {8{16'hFFFE}});
    send(mk(1, 1, 2, 1), {4{32'hFFFFFFFF}}, {2{64'hFFFFFFFFFFFFFFFF}});
    chk1("R6 wrap 64-bit lane", out_result, {2{64'h00000001FFFFFFFD}});
    send(mk(0, 1, 0, 0), {16{8'hFF}}, {128{1'b1}});
    chk1("R5 upper half zero", out_result, {64'd0, {4{16'h01FE}}});
    send(mk(1, 0, 1, 1), 128'h0, 128'h7FFFFFFF_00000000_7FFFFFFF_00000000);
    chk1("R4 accumulate passes old dst", out_result, 128'h7FFFFFFF_00000000_7FFFFFFF_00000000);

    // R1 non-matching words
    send(32'h8E206A00 | mk(1,0,0,1), 128'h1234, 128'hDEAD_BEEF);
    chk1("R1 bit31 set illegal", {127'd0, out_illegal}, 128'd1);
    chk1("R1 bit31 set passes dst", out_result, 128'hDEAD_BEEF);
    send(mk(1,0,0,1) ^ 32'h00000400, {16{8'h11}}, 128'h55);
    chk1("R1 bad function field", {127'd0, out_illegal}, 128'd1);
    chk1("R1 bad function passes dst", out_result, 128'h55);
    send(mk(1,0,0,1) | 32'h00010000, {16{8'h11}}, 128'h77);
    chk1("R1 bits20:16 nonzero", {127'd0, out_illegal}, 128'd1);
    send(mk(1,0,1,1), {8{16'h0001}}, '0);
    chk1("R1 legal clears flag", {127'd0, out_illegal}, 128'd0);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_insn = mk(1,1,0,0); in_src = {16{8'h01}}; in_dst = '0; in_valid = 1'b1;
    @(negedge clk);
    in_insn = mk(1,1,1,0); in_src = {8{16'h0002}};
    chk1("R9 first beat held", out_result, {8{16'h0002}});
    chk1("R9 in_ready low while stalled", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    chk1("R9 stall keeps first beat", out_result, {8{16'h0002}});
    chk1("R9 stall keeps valid", {127'd0, out_valid}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk1("R9 second beat after release", out_result, {4{32'h00000004}});
    @(negedge clk);
    chk1("R8 valid drops when drained", {127'd0, out_valid}, 128'd0);

    // R8 reset mid-stream
    @(negedge clk);
    in_insn = mk(1,0,0,0); in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk1("R8 reset clears pending beat", {127'd0, out_valid}, 128'd0);
    out_ready = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule